// File: doc/BRIEF.md
# Region Decoder with Bus Error and Port-Width Side-Band

This block sits in a shared-bus interconnect between one master and a set of slaves. It compares the master's address against a small table of regions fixed by parameters. Each region has a base, a mask and a slave port width. When a cycle is active it raises the select line of the matching slave. At the same time it drives a 2-bit side-band code that gives that slave's data-path width. A bridge can then adapt its transfers without knowing the slaves beforehand.

An address that falls in no region gets no select. The decoder answers that access itself with a one-cycle bus error, so the master can end the cycle. All outputs are registered and appear one clock after the request is presented. When regions overlap, the one with the lowest index wins.

The default table maps four regions into the lower half of a 16-bit space and leaves the upper half unmapped:

| Region | Address range | Width |
|---|---|---|
| 0 | 0x0000-0x3FFF | 32-bit |
| 1 | 0x4000-0x4FFF | 8-bit |
| 2 | 0x4000-0x5FFF | 16-bit |
| 3 | 0x6000-0x7FFF | 64-bit |

Region 1 lies inside region 2.

Top module: `bus_region_decoder`

## Requirements
- R1: After synchronous reset, sel_o is all zero, size_o is 2'b00 and err_o is low.
- R2: When cyc_i and stb_i are both high with an address inside region i, sel_o equals one-hot bit i on the next clock. It keeps that value for as long as the request and the address are held.
- R3: While a select is high, size_o gives that region's port width: 2'b00 is 8-bit, 2'b01 is 16-bit, 2'b10 is 32-bit and 2'b11 is 64-bit. The default regions 0 to 3 are 32-, 8-, 16- and 64-bit. When no select is high, size_o is 2'b00.
- R4: When cyc_i or stb_i is low, sel_o, size_o and err_o are all zero on the next clock.
- R5: A request to an address in no region raises err_o on the next clock, with sel_o all zero. With the default table this includes every address with bit 15 set.
- R6: err_o is high for exactly one cycle per request, even if the master keeps the strobe high. A new error is given only after the request is dropped and raised again.
- R7: When an address matches several regions, only the lowest-numbered one is selected. With the default table, 0x4000-0x4FFF selects region 1 and 0x5000-0x5FFF selects region 2.
- R8: At most one select bit is high at any time, and err_o is never high in the same cycle as a select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Master cycle-in-progress |
| stb_i | input | 1 | Master strobe |
| adr_i | input | ADDR_W | Master address |
| sel_o | output | N_REGIONS | One-hot slave selects, registered |
| size_o | output | 2 | Port width code of the selected slave |
| err_o | output | 1 | Bus error for unmapped addresses |

## Verification
The bench probes the first and last address of every region. A decoder with a wrong mask or base would select the wrong slave, or raise an error at one of those edges. Addresses inside the nested region check the priority order: a highest-index-wins picker would choose region 2 there. A held strobe to an unmapped address checks that the error is a single pulse that comes back only after the request is raised again; a level-style error would stay high or never return. Requests with only one of cyc_i and stb_i high must leave every output low.

// File: rtl/bus_region_pkg.sv
package bus_region_pkg;
  typedef enum logic [1:0] {
    PW8  = 2'b00,
    PW16 = 2'b01,
    PW32 = 2'b10,
    PW64 = 2'b11
  } port_width_t;
endpackage

// File: rtl/region_match.sv
module region_match #(
  parameter int AW = 16,
  parameter int N  = 4,
  parameter logic [N*AW-1:0] BASE = '0,
  parameter logic [N*AW-1:0] MASK = '0
) (
  input  logic [AW-1:0] adr,
  output logic [N-1:0]  hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    localparam logic [AW-1:0] M = MASK[i*AW +: AW];
    localparam logic [AW-1:0] B = BASE[i*AW +: AW] & M;
    assign hit[i] = ((adr & M) == B);
  end
endmodule

// File: rtl/priority_pick.sv
module priority_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  hit,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    onehot = '0;
    idx    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        onehot    = '0;
        onehot[i] = 1'b1;
        idx       = IW'(i);
      end
    end
  end
  assign any = |hit;
endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder
  import bus_region_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int N_REGIONS = 4,
  parameter logic [N_REGIONS*ADDR_W-1:0] REGION_BASE =
    {16'h6000, 16'h4000, 16'h4000, 16'h0000},
  parameter logic [N_REGIONS*ADDR_W-1:0] REGION_MASK =
    {16'hE000, 16'hE000, 16'hF000, 16'hC000},
  parameter logic [2*N_REGIONS-1:0] REGION_SIZE =
    {PW64, PW16, PW8, PW32}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cyc_i,
  input  logic                 stb_i,
  input  logic [ADDR_W-1:0]    adr_i,
  output logic [N_REGIONS-1:0] sel_o,
  output logic [1:0]           size_o,
  output logic                 err_o
);
  localparam int IDX_W = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1;

  logic [N_REGIONS-1:0] hit, pick;
  logic [IDX_W-1:0]     pick_idx;
  logic                 pick_any;
  logic                 req;
  logic                 err_seen;
  port_width_t          width_c;

  region_match #(
    .AW(ADDR_W), .N(N_REGIONS), .BASE(REGION_BASE), .MASK(REGION_MASK)
  ) u_match (
    .adr(adr_i), .hit(hit)
  );

  priority_pick #(.N(N_REGIONS), .IW(IDX_W)) u_pick (
    .hit(hit), .onehot(pick), .idx(pick_idx), .any(pick_any)
  );

  assign req     = cyc_i & stb_i;
  assign width_c = port_width_t'(REGION_SIZE[2*int'(pick_idx) +: 2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o    <= '0;
      size_o   <= PW8;
      err_o    <= 1'b0;
      err_seen <= 1'b0;
    end else begin
      sel_o    <= req ? pick : '0;
      size_o   <= (req && pick_any) ? width_c : PW8;
      err_o    <= req && !pick_any && !err_o && !err_seen;
      err_seen <= req && (err_seen || err_o);
    end
  end
endmodule

// File: rtl/bus_region_decoder_chk.sv
module bus_region_decoder_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         cyc_i,
  input logic         stb_i,
  input logic [N-1:0] sel_o,
  input logic [1:0]   size_o,
  input logic         err_o
);
  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o));
  // R8
  sel_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (sel_o == '0));
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(cyc_i && stb_i) |=> (sel_o == '0) && !err_o && (size_o == 2'b00));
  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
  // R3
  size_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (size_o != 2'b00) |-> (sel_o != '0));
  // R2
  sel_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_o != '0) |-> $past(cyc_i && stb_i));
  // R5
  err_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> $past(cyc_i && stb_i));
endmodule

bind bus_region_decoder bus_region_decoder_chk #(.N(N_REGIONS)) u_chk (
  .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i),
  .sel_o(sel_o), .size_o(size_o), .err_o(err_o)
);

// File: tb/bus_region_decoder_test.sv
`timescale 1ns/1ps
module bus_region_decoder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cyc_i, stb_i;
  logic [15:0] adr_i;
  logic [3:0]  sel_o;
  logic [1:0]  size_o;
  logic        err_o;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bus_region_decoder uut (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .adr_i(adr_i),
    .sel_o(sel_o), .size_o(size_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int region_of(input logic [15:0] a);
    if (a < 16'h4000) return 0;
    if (a < 16'h5000) return 1;
    if (a < 16'h6000) return 2;
    if (a < 16'h8000) return 3;
    return -1;
  endfunction

  function automatic logic [1:0] width_of(input int r);
    case (r)
      0: return 2'b10;
      1: return 2'b00;
      2: return 2'b01;
      3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic idle();
    @(negedge clk); cyc_i = 0; stb_i = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic test_reset();
    rst = 1; cyc_i = 0; stb_i = 0; adr_i = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R1 sel", {4'b0, sel_o}, 8'h00);
    chk("R1 size", {6'b0, size_o}, 8'h00);
    chk("R1 err", {7'b0, err_o}, 8'h00);
  endtask

  task automatic test_access(input logic [15:0] a, input string tag);
    int r;
    logic [3:0] exp_sel;
    r = region_of(a);
    exp_sel = (r >= 0) ? (4'b1 << r) : 4'b0;
    @(negedge clk); cyc_i = 1; stb_i = 1; adr_i = a;
    @(posedge clk); @(negedge clk);
    chk({tag, " sel"}, {4'b0, sel_o}, {4'b0, exp_sel});
    chk({tag, " size R3"}, {6'b0, size_o}, {6'b0, width_of(r)});
    chk({tag, " err"}, {7'b0, err_o}, {7'b0, (r < 0)});
    @(posedge clk); @(negedge clk);
    chk({tag, " held sel"}, {4'b0, sel_o}, {4'b0, exp_sel});
    idle();
  endtask

  task automatic test_err_hold();
    @(negedge clk); cyc_i = 1; stb_i = 1; adr_i = 16'h9ABC;
    @(posedge clk); @(negedge clk);
    chk("R5 err raised", {7'b0, err_o}, 8'h01);
    chk("R5 no sel", {4'b0, sel_o}, 8'h00);
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      chk("R6 err single pulse", {7'b0, err_o}, 8'h00);
    end
    idle();
    chk("R6 err low after drop", {7'b0, err_o}, 8'h00);
    @(negedge clk); cyc_i = 1; stb_i = 1;
    @(posedge clk); @(negedge clk);
    chk("R6 err again", {7'b0, err_o}, 8'h01);
    idle();
  endtask

  task automatic test_half(input logic c, input logic s, input logic [15:0] a);
    @(negedge clk); cyc_i = c; stb_i = s; adr_i = a;
    @(posedge clk); @(negedge clk);
    chk("R4 sel", {4'b0, sel_o}, 8'h00);
    chk("R4 err", {7'b0, err_o}, 8'h00);
    chk("R4 size", {6'b0, size_o}, 8'h00);
    idle();
  endtask

  initial begin
    #1900000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_access(16'h0000, "R2 r0 low");
    test_access(16'h3FFF, "R2 r0 high");
    test_access(16'h4000, "R7 r1 low");
    test_access(16'h4800, "R7 r1 mid");
    test_access(16'h4FFF, "R7 r1 high");
    test_access(16'h5000, "R7 r2 low");
    test_access(16'h5FFF, "R2 r2 high");
    test_access(16'h6000, "R2 r3 low");
    test_access(16'h7FFF, "R2 r3 high");
    test_access(16'h8000, "R5 unmapped low");
    test_access(16'hFFFF, "R5 unmapped top");
    test_err_hold();
    test_half(1'b1, 1'b0, 16'h1234);
    test_half(1'b0, 1'b1, 16'h1234);
    test_half(1'b1, 1'b0, 16'hC000);
    test_access(16'h2000, "R8 after idle");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule